// File: doc/BRIEF.md
# Dual-Clock Rewindable Word Queue

This block carries 36-bit words in one direction, from a producer on `wr_clk` to a consumer on `rd_clk`. Both clocks run freely. They may be unrelated, or they may be the very same net, in which case a push and a pop on one edge both take effect. Each side has a valid/ready stream:

- A word moves on a rising edge of its own clock only when valid and ready are both high.
- The producer may hold `wr_valid` with a word for as long as `wr_ready` is low. Nothing is taken until ready returns.
- The consumer sees the oldest unread word on `rd_data` whenever `rd_valid` is high, in first-word-fall-through fashion. It pops that word by raising `rd_ready`.

Each side has a threshold flag computed in its own clock domain:

- On the producer side, `wr_almost_full` compares the free space against a programmable offset.
- On the consumer side, `rd_almost_empty` compares the stored word count against a second offset.

Positions cross between the domains as Gray code through two-flop synchronisers. A flag therefore turns on at once for a local event, but turns off only a few cycles of the local clock after the far side moves.

For repeat reads, raising `rt_mode` on the consumer side records the position of the next unread word as a mark. While the mode stays active, the producer side protects every word from the mark onward. A one-cycle `rt_rewind` then returns the consumer to the mark, so the same words can be read again. When `rt_mode` drops, the protected region is released one word per read clock.

Top module: `rewind_fifo`

## Requirements
- R1: Every word accepted on the write stream appears on `rd_data` in acceptance order, with all 36 bits intact. Outside a rewind, no word is lost or repeated.
- R2: `wr_ready` is low exactly when DEPTH words are held from the write side's point of view. A push offered while `wr_ready` is low is not stored and does not advance the write position.
- R3: `rd_valid` is low exactly when the read side sees no unread word. `rd_ready` raised while `rd_valid` is low does not move the read position.
- R4: Once the pointers have settled, `wr_almost_full` is high when DEPTH minus the stored count is at or below the full offset.
- R5: Once the pointers have settled, `rd_almost_empty` is high when the unread count is at or below the empty offset.
- R6: A one-cycle `af_ofs_load` on `wr_clk` loads the full offset from `af_ofs_value`. A one-cycle `ae_ofs_load` on `rd_clk` loads the empty offset from `ae_ofs_value`. Reset sets both offsets to 8.
- R7: `rst` is synchronous and active high, and is sampled in both clock domains. It clears both positions. After reset, `wr_ready`=1, `rd_valid`=0, `rd_almost_empty`=1 and `wr_almost_full`=0.
- R8: The first `rd_clk` edge that sees `rt_mode` high records the current read position as the mark. The mode becomes active from that edge, and the mark holds while the mode stays active.
- R9: `rt_rewind` sampled high while the mode is active sets the read position to the mark, and any pop on that edge is dropped. `rt_rewind` while the mode is inactive has no effect.
- R10: While the mode is active, the write side counts stored words from the mark, so `wr_ready` drops when DEPTH words lie at or after the mark. After the mode ends, that space is released within DEPTH read cycles.
- R11: With `wr_clk` and `rd_clk` driven by one clock, simultaneous pushes and pops on the same edge keep the behaviour of R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| rst | input | 1 | Synchronous active-high reset, seen in both domains |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Space available (input-ready) |
| wr_data | input | 36 | Word offered |
| wr_almost_full | output | 1 | Free space at or below full offset |
| af_ofs_load | input | 1 | Load full offset (wr_clk) |
| af_ofs_value | input | AW+1 | New full offset |
| rd_valid | output | 1 | Word present (output-ready) |
| rd_ready | input | 1 | Consumer pops the presented word |
| rd_data | output | 36 | Oldest unread word |
| rd_almost_empty | output | 1 | Unread count at or below empty offset |
| ae_ofs_load | input | 1 | Load empty offset (rd_clk) |
| ae_ofs_value | input | AW+1 | New empty offset |
| rt_mode | input | 1 | Retransmit mode level (rd_clk) |
| rt_rewind | input | 1 | Return read position to mark (rd_clk) |

## Verification
A read position that drifts by even one word shows on the next accepted pop as a wrong or repeated value on `rd_data`. A corrupt mark shows on the first word presented after a rewind. A write position that moves on a refused push leaves an extra stale word in the stream, which the drain after a full fill exposes. Threshold or synchroniser faults show as a wrong `wr_ready`, `rd_valid` or almost flag a few local cycles after traffic stops. The bench therefore compares flags only once both sides have settled.

// File: rtl/rwf_pkg.sv
`timescale 1ns/1ps
package rwf_pkg;
  localparam int unsigned WORD_W  = 36;
  localparam int unsigned OFS_DEF = 8;

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) b[i] = ^(g >> i);
    return b;
  endfunction
endpackage

// File: rtl/rwf_sync.sv
`timescale 1ns/1ps
module rwf_sync #(
  parameter int unsigned W      = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rwf_ram.sv
`timescale 1ns/1ps
module rwf_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned W     = 36,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rwf_wr_ctl.sv
`timescale 1ns/1ps
module rwf_wr_ctl #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  output logic          push_ready,
  output logic          push_en,
  input  logic [PW-1:0] tail_gray_s,
  input  logic          ofs_load,
  input  logic [PW-1:0] ofs_value,
  output logic          almost_full,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wptr_gray
);
  import rwf_pkg::*;

  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [PW-1:0] tail_bin, used, free_cnt, wptr_nx, af_ofs;
  logic [31:0]   tail_wide, gray_wide;

  assign tail_wide  = gray2bin(32'(tail_gray_s));
  assign tail_bin   = tail_wide[PW-1:0];
  assign used       = wptr - tail_bin;
  assign free_cnt   = CAP - used;
  assign push_ready = (used != CAP);
  assign push_en    = push_valid & push_ready;
  assign almost_full = (free_cnt <= af_ofs);

  assign wptr_nx   = wptr + PW'(1);
  assign gray_wide = bin2gray(32'(wptr_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      wptr_gray <= '0;
      af_ofs    <= PW'(OFS_DEF);
    end else begin
      if (push_en) begin
        wptr      <= wptr_nx;
        wptr_gray <= gray_wide[PW-1:0];
      end
      if (ofs_load) af_ofs <= ofs_value;
    end
  end
endmodule

// File: rtl/rwf_rd_ctl.sv
`timescale 1ns/1ps
module rwf_rd_ctl #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop_ready,
  output logic          pop_valid,
  input  logic [PW-1:0] wptr_gray_s,
  input  logic          ofs_load,
  input  logic [PW-1:0] ofs_value,
  output logic          almost_empty,
  input  logic          rt_mode,
  input  logic          rt_rewind,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] mark,
  output logic          rt_active,
  output logic [PW-1:0] tail,
  output logic [PW-1:0] tail_gray
);
  import rwf_pkg::*;

  logic [PW-1:0] wptr_bin, avail, ae_ofs, target, tail_nx;
  logic [31:0]   wptr_wide, tgray_wide;
  logic          enter, do_rewind, pop_en;

  assign wptr_wide    = gray2bin(32'(wptr_gray_s));
  assign wptr_bin     = wptr_wide[PW-1:0];
  assign avail        = wptr_bin - rptr;
  assign pop_valid    = (avail != '0);
  assign almost_empty = (avail <= ae_ofs);

  assign enter     = rt_mode & ~rt_active;
  assign do_rewind = rt_rewind & rt_active;
  assign pop_en    = pop_valid & pop_ready & ~do_rewind;

  // The released boundary walks one word per cycle so its Gray image changes one bit at a time.
  assign target     = rt_active ? mark : rptr;
  assign tail_nx    = tail + PW'(1);
  assign tgray_wide = bin2gray(32'(tail_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      mark      <= '0;
      rt_active <= 1'b0;
      tail      <= '0;
      tail_gray <= '0;
      ae_ofs    <= PW'(OFS_DEF);
    end else begin
      rt_active <= rt_mode;
      if (enter) mark <= rptr;
      if (do_rewind)   rptr <= mark;
      else if (pop_en) rptr <= rptr + PW'(1);
      if (tail != target) begin
        tail      <= tail_nx;
        tail_gray <= tgray_wide[PW-1:0];
      end
      if (ofs_load) ae_ofs <= ofs_value;
    end
  end
endmodule

// File: rtl/rewind_fifo.sv
`timescale 1ns/1ps
module rewind_fifo #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic                      wr_clk,
  input  logic                      rd_clk,
  input  logic                      rst,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [rwf_pkg::WORD_W-1:0] wr_data,
  output logic                      wr_almost_full,
  input  logic                      af_ofs_load,
  input  logic [PW-1:0]             af_ofs_value,
  output logic                      rd_valid,
  input  logic                      rd_ready,
  output logic [rwf_pkg::WORD_W-1:0] rd_data,
  output logic                      rd_almost_empty,
  input  logic                      ae_ofs_load,
  input  logic [PW-1:0]             ae_ofs_value,
  input  logic                      rt_mode,
  input  logic                      rt_rewind
);
  import rwf_pkg::*;

  logic          w_en;
  logic [PW-1:0] w_ptr, w_gray, w_gray_s;
  logic [PW-1:0] r_ptr, r_mark, r_tail, r_tail_gray, r_tail_gray_s;
  logic          r_active;

  rwf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst(rst),
    .push_valid(wr_valid), .push_ready(wr_ready), .push_en(w_en),
    .tail_gray_s(r_tail_gray_s),
    .ofs_load(af_ofs_load), .ofs_value(af_ofs_value),
    .almost_full(wr_almost_full),
    .wptr(w_ptr), .wptr_gray(w_gray)
  );

  rwf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst(rst),
    .pop_ready(rd_ready), .pop_valid(rd_valid),
    .wptr_gray_s(w_gray_s),
    .ofs_load(ae_ofs_load), .ofs_value(ae_ofs_value),
    .almost_empty(rd_almost_empty),
    .rt_mode(rt_mode), .rt_rewind(rt_rewind),
    .rptr(r_ptr), .mark(r_mark), .rt_active(r_active),
    .tail(r_tail), .tail_gray(r_tail_gray)
  );

  rwf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rst), .d(w_gray), .q(w_gray_s)
  );

  rwf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(rst), .d(r_tail_gray), .q(r_tail_gray_s)
  );

  rwf_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .wclk(wr_clk), .we(w_en), .waddr(w_ptr[AW-1:0]), .wdata(wr_data),
    .raddr(r_ptr[AW-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/rewind_fifo_chk.sv
`timescale 1ns/1ps
module rewind_fifo_chk #(
  parameter int unsigned PW = 10
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_almost_full,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rd_almost_empty,
  input logic          rt_rewind,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] mark,
  input logic          rt_active,
  input logic [PW-1:0] tail
);
  AST_RESET_WPTR: assert property (@(posedge wr_clk) rst |=> (wptr == '0)); // R7
  AST_RESET_RPTR: assert property (@(posedge rd_clk) rst |=> (rptr == '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wptr == $past(wptr))); // R2
  AST_WR_STEP: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (wptr == $past(wptr) + PW'(1))); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_ready && !rd_valid && !rt_rewind) |=> (rptr == $past(rptr))); // R3
  AST_FULL_AF: assert property (@(posedge wr_clk) disable iff (rst)
    !wr_ready |-> wr_almost_full); // R4
  AST_EMPTY_AE: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_valid |-> rd_almost_empty); // R5
  AST_MARK_HELD: assert property (@(posedge rd_clk) disable iff (rst)
    rt_active |=> $stable(mark)); // R8
  AST_REWIND: assert property (@(posedge rd_clk) disable iff (rst)
    (rt_rewind && rt_active) |=> (rptr == $past(mark))); // R9
  AST_TAIL_STEP: assert property (@(posedge rd_clk) disable iff (rst)
    1'b1 |=> (tail == $past(tail) || tail == $past(tail) + PW'(1))); // R10
endmodule

bind rewind_fifo rewind_fifo_chk #(.PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_almost_full(wr_almost_full),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_almost_empty(rd_almost_empty),
  .rt_rewind(rt_rewind), .wptr(w_ptr), .rptr(r_ptr), .mark(r_mark),
  .rt_active(r_active), .tail(r_tail)
);

// File: tb/test_rewind_fifo.sv
`timescale 1ns/1ps
module test_rewind_fifo;
  localparam int DEPTH = 512;
  localparam int PW    = 10;

  logic wclk = 0, rclk_free = 0, same_clk = 0;
  wire  rd_clk = same_clk ? wclk : rclk_free;
  always #2.5 wclk = ~wclk;
  always #3.5 rclk_free = ~rclk_free;

  logic          rst = 1;
  logic          wr_valid = 0, wr_ready, wr_almost_full;
  logic [35:0]   wr_data = '0, rd_data;
  logic          af_ofs_load = 0, ae_ofs_load = 0;
  logic [PW-1:0] af_ofs_value = '0, ae_ofs_value = '0;
  logic          rd_valid, rd_ready = 0, rd_almost_empty;
  logic          rt_mode = 0, rt_rewind = 0;

  rewind_fifo #(.DEPTH(DEPTH)) i_rewind_fifo (
    .wr_clk(wclk), .rd_clk(rd_clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_almost_full(wr_almost_full),
    .af_ofs_load(af_ofs_load), .af_ofs_value(af_ofs_value),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_almost_empty(rd_almost_empty),
    .ae_ofs_load(ae_ofs_load), .ae_ofs_value(ae_ofs_value),
    .rt_mode(rt_mode), .rt_rewind(rt_rewind)
  );

  int n_run = 0, n_fail = 0;
  logic [35:0] hist [int];
  int wcnt = 0, ridx = 0, markidx = 0, af_m = 8, ae_m = 8;

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_af(input int wused);
    return (DEPTH - wused) <= af_m;
  endfunction
  function automatic bit exp_ae(input int rused);
    return rused <= ae_m;
  endfunction

  task automatic do_reset();
    wr_valid = 0; rd_ready = 0; rt_mode = 0; rt_rewind = 0;
    rst = 1;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wclk);
    rst = 0;
    hist.delete(); wcnt = 0; ridx = 0; markidx = 0; af_m = 8; ae_m = 8;
  endtask

  task automatic write_n(input int n, input int pct);
    int got = 0;
    while (got < n) begin
      @(negedge wclk);
      if ($urandom_range(99) < pct) begin
        wr_valid = 1;
        wr_data  = {4'($urandom), $urandom};
        if (wr_ready) begin
          hist[wcnt] = wr_data; wcnt++; got++;
        end
      end else wr_valid = 0;
    end
    @(negedge wclk);
    wr_valid = 0;
  endtask

  task automatic read_n(input int n, input int pct, input string tag);
    int got = 0;
    while (got < n) begin
      @(negedge rd_clk);
      rd_ready = ($urandom_range(99) < pct);
      if (rd_ready && rd_valid) begin
        chk(rd_data == hist[ridx], tag, rd_data, hist[ridx]);
        ridx++; got++;
      end
    end
    @(negedge rd_clk);
    rd_ready = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge rd_clk);
    repeat (n) @(negedge wclk);
  endtask

  task automatic check_flags(input string tag, input int wused, input int rused);
    @(negedge wclk);
    chk(wr_ready == (wused < DEPTH), {tag, " wr_ready"}, 36'(wr_ready), 36'(wused < DEPTH));
    chk(wr_almost_full == exp_af(wused), {tag, " almost_full"}, 36'(wr_almost_full), 36'(exp_af(wused)));
    @(negedge rd_clk);
    chk(rd_valid == (rused > 0), {tag, " rd_valid"}, 36'(rd_valid), 36'(rused > 0));
    chk(rd_almost_empty == exp_ae(rused), {tag, " almost_empty"}, 36'(rd_almost_empty), 36'(exp_ae(rused)));
  endtask

  task automatic pulse_rewind();
    @(negedge rd_clk); rt_rewind = 1;
    @(negedge rd_clk); rt_rewind = 0;
  endtask

  initial begin
    repeat (190000) @(posedge wclk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_0031);
    do_reset();
    settle(6);
    check_flags("R7", 0, 0);

    // R5 boundary around default offset
    write_n(20, 100); settle(8); check_flags("R5", 20, 20);
    read_n(11, 100, "R1"); settle(8); check_flags("R5", 9, 9);
    read_n(1, 100, "R1"); settle(8); check_flags("R5", 8, 8);
    read_n(8, 100, "R1"); settle(8); check_flags("R3", 0, 0);

    // R3 pops while empty are ignored
    @(negedge rd_clk); rd_ready = 1;
    repeat (6) @(negedge rd_clk);
    chk(rd_valid == 0, "R3 empty", 36'(rd_valid), 36'(0));
    rd_ready = 0;
    write_n(1, 100); settle(8);
    read_n(1, 100, "R3");

    // R2 fill and refused pushes
    write_n(DEPTH, 100); settle(8); check_flags("R2", DEPTH, DEPTH);
    @(negedge wclk); wr_valid = 1; wr_data = 36'hBAD_BAD_BAD;
    repeat (8) begin
      @(negedge wclk);
      chk(wr_ready == 0, "R2 full", 36'(wr_ready), 36'(0));
    end
    wr_valid = 0;
    read_n(8, 100, "R2"); settle(8); check_flags("R4", DEPTH-8, DEPTH-8);
    read_n(1, 100, "R2"); settle(8); check_flags("R4", DEPTH-9, DEPTH-9);

    // R6 offset load
    @(negedge wclk); af_ofs_load = 1; af_ofs_value = PW'(100);
    @(negedge wclk); af_ofs_load = 0; af_m = 100;
    @(negedge rd_clk); ae_ofs_load = 1; ae_ofs_value = PW'(300);
    @(negedge rd_clk); ae_ofs_load = 0; ae_m = 300;
    settle(4); check_flags("R6", 503, 503);
    read_n(202, 100, "R2"); settle(8); check_flags("R6", 301, 301);
    read_n(1, 100, "R2"); settle(8); check_flags("R6", 300, 300);
    read_n(300, 100, "R2"); settle(8); check_flags("R2", 0, 0);

    // R1 random traffic
    fork
      write_n(2000, 60);
      read_n(2000, 45, "R1");
    join
    settle(8); check_flags("R1", 0, 0);

    // R6 defaults restored by reset
    do_reset(); settle(6);
    write_n(9, 100); settle(8); check_flags("R6", 9, 9);
    write_n(21, 100);
    read_n(5, 100, "R1");

    // R8 / R9 mark and rewind
    @(negedge rd_clk); rt_mode = 1; markidx = ridx;
    @(negedge rd_clk);
    read_n(10, 100, "R8");
    pulse_rewind(); ridx = markidx;
    chk(rd_data == hist[markidx], "R9 rewind", rd_data, hist[markidx]);
    read_n(25, 100, "R9");
    settle(8); check_flags("R10", wcnt - markidx, 0);

    // R9 rewind beats a pop on the same edge
    write_n(2, 100); settle(8);
    @(negedge rd_clk); rd_ready = 1; rt_rewind = 1;
    @(negedge rd_clk); rd_ready = 0; rt_rewind = 0; ridx = markidx;
    chk(rd_data == hist[markidx], "R9 priority", rd_data, hist[markidx]);
    read_n(wcnt - ridx, 100, "R9");

    // R10 protected region limits space
    write_n(DEPTH - (wcnt - markidx), 100); settle(8);
    check_flags("R10", DEPTH, wcnt - ridx);
    pulse_rewind(); ridx = markidx;
    read_n(DEPTH, 100, "R10");
    @(negedge rd_clk); rt_mode = 0;
    settle(DEPTH + 20); check_flags("R10", 0, 0);

    // R9 rewind ignored when mode inactive
    write_n(3, 100); settle(8);
    read_n(1, 100, "R9");
    pulse_rewind(); settle(2);
    chk(rd_data == hist[ridx], "R9 inactive", rd_data, hist[ridx]);
    read_n(2, 100, "R9"); settle(8); check_flags("R9", 0, 0);

    // R11 one shared clock
    same_clk = 1;
    do_reset(); settle(6); check_flags("R11", 0, 0);
    fork
      write_n(1500, 70);
      read_n(1500, 70, "R11");
    join
    write_n(20, 100); settle(8);
    fork
      write_n(200, 100);
      read_n(200, 100, "R11");
    join
    read_n(20, 100, "R11");
    settle(8); check_flags("R11", 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule